// File: doc/BRIEF.md
# Predicated Byte Scatter-Store Sequencer

This block turns one scatter-store command into a series of single-byte memory write requests. A command brings a 32-bit instruction word, a vector of base addresses, a source data vector, a byte-granular governing predicate and the value of a 64-bit scalar offset register. The block decodes the word to find the element width (32 or 64 bits) and whether the offset register is the zero register. It then walks the elements from lowest to highest and skips any element whose governing predicate bit is clear. For each active element it emits one write. The write address is the zero-extended base element plus the offset. The data is the low byte of the matching source element. Every write carries a streaming (non-temporal) hint.

Writes leave through a valid/ready request port. When the last write has been accepted, the block pulses `done` and returns to idle. A word that matches neither encoding raises a one-cycle `undef` pulse and produces no writes. A command with no active element completes at once, without capturing its operands. The vector length is the parameter `VLEN`.

Top module: `byte_scatter_seq`

## Requirements
- R1: A word whose bits 31:21 are 11100100010 and whose bits 15:13 are 001 is decoded as the 32-bit element form, with VLEN/32 elements. Element e occupies bits e*32 upward of the base and source vectors.
- R2: A word whose bits 31:21 are 11100100000 and whose bits 15:13 are 001 is decoded as the 64-bit element form, with VLEN/64 elements. Element e occupies bits e*64 upward of the base and source vectors.
- R3: Any other word gives `undef` high for exactly the one cycle after acceptance, with no write and no `done`.
- R4: The write address is the base element, zero-extended to 64 bits, plus the 64-bit offset, taken modulo 2^64.
- R5: When bits 20:16 of the word equal 31, the offset is zero whatever `cmd_offset` holds.
- R6: `wr_data` is bits 7:0 of the source element. The remaining bits of the element are dropped.
- R7: Element e is active only when predicate bit e*(esize/8) is set, that is bit 4e in the 32-bit form and bit 8e in the 64-bit form. Other predicate bits have no effect, and an inactive element issues no write.
- R8: Writes are issued in ascending element order, with exactly one write per active element.
- R9: A request whose `wr_ready` is low keeps `wr_valid`, `wr_addr` and `wr_data` unchanged in the next cycle.
- R10: `wr_stream` is high on every write request.
- R11: A legal command with no active element gives `done` in the cycle after acceptance and issues no write.
- R12: `cmd_ready` is high only when the block is idle, and a command presented while the block is busy is ignored. `done` is high for one cycle, in the cycle after the last write is accepted, and `wr_valid` is low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block idle; the command is accepted when valid and ready are both high |
| cmd_insn | input | 32 | Instruction word |
| cmd_base | input | VLEN | Base address vector |
| cmd_src | input | VLEN | Source data vector |
| cmd_pred | input | VLEN/8 | Governing predicate, one bit per vector byte |
| cmd_offset | input | 64 | Value of the scalar offset register |
| wr_valid | output | 1 | Write request valid |
| wr_ready | input | 1 | Memory accepts the request |
| wr_addr | output | 64 | Byte address |
| wr_data | output | 8 | Byte to store |
| wr_stream | output | 1 | Non-temporal hint |
| done | output | 1 | Command complete pulse |
| undef | output | 1 | Undefined-instruction pulse |

## Verification
Take the rising edge that accepts a command as edge 0. `undef`, and `done` for a command with no active element, are due one cycle after edge 0. In an active command, `wr_valid` stays low in that cycle, and the first request is due one cycle later. Each following request appears in the cycle after the handshake of the request before it, and `done` appears in the cycle after the last handshake. The bench holds a queue of expected writes built from the requirements. It samples all outputs on every falling edge and compares each cycle with the value the queue and the handshake history call for. Stalled handshakes therefore also check that a held request stays unchanged.

// File: rtl/scat_pkg.sv
package scat_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_SEND = 2'd2
  } scat_state_t;

  typedef struct packed {
    logic legal;     // matches one of the two encodings
    logic wide;      // 64-bit element form
    logic zero_off;  // offset register field selects the zero register
  } scat_dec_t;

  localparam logic [10:0] OPC_NARROW = 11'b11100100010;
  localparam logic [10:0] OPC_WIDE   = 11'b11100100000;
  localparam logic [2:0]  OPC_MID    = 3'b001;

endpackage

// File: rtl/scat_decode.sv
module scat_decode
  import scat_pkg::*;
(
  input  logic [31:0] word,
  output scat_dec_t   dec
);

  logic narrow_hit;
  logic wide_hit;
  logic unused_fields;

  assign narrow_hit = (word[31:21] == OPC_NARROW) && (word[15:13] == OPC_MID);
  assign wide_hit   = (word[31:21] == OPC_WIDE)   && (word[15:13] == OPC_MID);

  // Register-number fields for data, base and predicate are carried by the command itself
  assign unused_fields = ^word[12:0];

  always_comb begin
    dec.legal    = narrow_hit | wide_hit;
    dec.wide     = wide_hit;
    dec.zero_off = (word[20:16] == 5'd31);
  end

endmodule

// File: rtl/scat_pick.sv
module scat_pick #(
  parameter int N  = 8,
  parameter int IW = 4
) (
  input  logic [N-1:0]  mask,
  input  logic [IW-1:0] from,
  output logic          found,
  output logic [IW-1:0] idx
);

  // Lowest set mask bit at or above 'from'
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = 0; i < N; i++) begin
      if (!found && mask[i] && (IW'(i) >= from)) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end

endmodule

// File: rtl/scat_lane.sv
module scat_lane #(
  parameter int VLEN = 256,
  parameter int AW   = 3
) (
  input  logic [VLEN-1:0] base,
  input  logic [VLEN-1:0] src,
  input  logic            wide,
  input  logic [AW-1:0]   idx,
  input  logic [63:0]     offset,
  output logic [63:0]     addr,
  output logic [7:0]      byte_out
);

  localparam int NE  = VLEN / 32;
  localparam int NW  = VLEN / 64;
  localparam int AWW = (NW > 1) ? $clog2(NW) : 1;

  logic [31:0] base32 [NE];
  logic [63:0] base64 [NW];
  logic [7:0]  low32  [NE];
  logic [7:0]  low64  [NW];

  for (genvar g = 0; g < NE; g++) begin : g_narrow
    assign base32[g] = base[g*32 +: 32];
    assign low32[g]  = src[g*32 +: 8];
  end

  for (genvar g = 0; g < NW; g++) begin : g_wide
    assign base64[g] = base[g*64 +: 64];
    assign low64[g]  = src[g*64 +: 8];
  end

  logic [63:0] elem;

  always_comb begin
    if (wide) begin
      elem     = base64[idx[AWW-1:0]];
      byte_out = low64[idx[AWW-1:0]];
    end else begin
      elem     = {32'b0, base32[idx]};
      byte_out = low32[idx];
    end
    addr = elem + offset;
  end

endmodule

// File: rtl/byte_scatter_seq.sv
module byte_scatter_seq
  import scat_pkg::*;
#(
  parameter int VLEN = 256
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [31:0]       cmd_insn,
  input  logic [VLEN-1:0]   cmd_base,
  input  logic [VLEN-1:0]   cmd_src,
  input  logic [VLEN/8-1:0] cmd_pred,
  input  logic [63:0]       cmd_offset,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [63:0]       wr_addr,
  output logic [7:0]        wr_data,
  output logic              wr_stream,
  output logic              done,
  output logic              undef
);

  localparam int NE = VLEN / 32;
  localparam int NW = VLEN / 64;
  localparam int AW = $clog2(NE);
  localparam int IW = AW + 1;

  scat_state_t st;
  scat_dec_t   dec;

  logic            wide_q;
  logic [VLEN-1:0] base_q;
  logic [VLEN-1:0] src_q;
  logic [NE-1:0]   pmask_q;
  logic [63:0]     off_q;
  logic [IW-1:0]   cur_idx;

  logic [NE-1:0]   cmd_mask;
  logic            accept;
  logic [IW-1:0]   pick_from;
  logic            pick_found;
  logic [IW-1:0]   pick_idx;
  logic [63:0]     lane_addr;
  logic [7:0]      lane_byte;
  logic            unused_bits;

  scat_decode u_dec (
    .word (cmd_insn),
    .dec  (dec)
  );

  // Governing bit for element e: byte e*4 (narrow) or e*8 (wide)
  for (genvar g = 0; g < NE; g++) begin : g_mask
    if (g < NW) begin : g_both
      assign cmd_mask[g] = dec.wide ? cmd_pred[g*8] : cmd_pred[g*4];
    end else begin : g_narrow_only
      assign cmd_mask[g] = dec.wide ? 1'b0 : cmd_pred[g*4];
    end
  end

  assign unused_bits = ^{cmd_pred, cmd_src};

  assign cmd_ready = (st == ST_IDLE);
  assign accept    = cmd_valid && cmd_ready;
  assign pick_from = (st == ST_SCAN) ? '0 : cur_idx + IW'(1);

  scat_pick #(.N(NE), .IW(IW)) u_pick (
    .mask  (pmask_q),
    .from  (pick_from),
    .found (pick_found),
    .idx   (pick_idx)
  );

  scat_lane #(.VLEN(VLEN), .AW(AW)) u_lane (
    .base     (base_q),
    .src      (src_q),
    .wide     (wide_q),
    .idx      (pick_idx[AW-1:0]),
    .offset   (off_q),
    .addr     (lane_addr),
    .byte_out (lane_byte)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      wr_valid  <= 1'b0;
      wr_stream <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
      done      <= 1'b0;
      undef     <= 1'b0;
      cur_idx   <= '0;
      pmask_q   <= '0;
      wide_q    <= 1'b0;
      off_q     <= '0;
    end else begin
      done  <= 1'b0;
      undef <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (accept) begin
            if (!dec.legal) begin
              undef <= 1'b1;
            end else if (cmd_mask == '0) begin
              done <= 1'b1;
            end else begin
              wide_q  <= dec.wide;
              pmask_q <= cmd_mask;
              off_q   <= dec.zero_off ? 64'd0 : cmd_offset;
              st      <= ST_SCAN;
            end
          end
        end
        ST_SCAN: begin
          wr_valid  <= 1'b1;
          wr_stream <= 1'b1;
          wr_addr   <= lane_addr;
          wr_data   <= lane_byte;
          cur_idx   <= pick_idx;
          st        <= ST_SEND;
        end
        ST_SEND: begin
          if (wr_ready) begin
            if (pick_found) begin
              wr_addr <= lane_addr;
              wr_data <= lane_byte;
              cur_idx <= pick_idx;
            end else begin
              wr_valid  <= 1'b0;
              wr_stream <= 1'b0;
              done      <= 1'b1;
              st        <= ST_IDLE;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // Operand vectors: plain storage with no reset
  always_ff @(posedge clk) begin
    if (accept && dec.legal && (cmd_mask != '0)) begin
      base_q <= cmd_base;
      src_q  <= cmd_src;
    end
  end

  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

  assert_order_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && wr_ready) |=> (!wr_valid || (cur_idx > $past(cur_idx))));

  assert_active_R7: assert property (@(posedge clk) disable iff (rst)
    wr_valid |-> pmask_q[cur_idx[AW-1:0]]);

  assert_stream_R10: assert property (@(posedge clk) disable iff (rst)
    wr_valid |-> wr_stream);

  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (rst)
    cmd_ready |-> !wr_valid);

  assert_undef_silent_R3: assert property (@(posedge clk) disable iff (rst)
    undef |-> (!done && !wr_valid));

endmodule

// File: tb/byte_scatter_seq_tb_top.sv
module byte_scatter_seq_tb_top;

  localparam int VLEN   = 256;
  localparam int PERIOD = 10;
  localparam int PB     = VLEN / 8;

  logic            clk = 1'b0;
  logic            rst;
  logic            cmd_valid;
  logic            cmd_ready;
  logic [31:0]     cmd_insn;
  logic [VLEN-1:0] cmd_base;
  logic [VLEN-1:0] cmd_src;
  logic [PB-1:0]   cmd_pred;
  logic [63:0]     cmd_offset;
  logic            wr_valid;
  logic            wr_ready;
  logic [63:0]     wr_addr;
  logic [7:0]      wr_data;
  logic            wr_stream;
  logic            done;
  logic            undef;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(PERIOD/2) clk = ~clk;

  byte_scatter_seq #(.VLEN(VLEN)) dut_i (
    .clk, .rst, .cmd_valid, .cmd_ready, .cmd_insn, .cmd_base, .cmd_src,
    .cmd_pred, .cmd_offset, .wr_valid, .wr_ready, .wr_addr, .wr_data,
    .wr_stream, .done, .undef
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input bit wide, input logic [4:0] rm);
    return {(wide ? 11'b11100100000 : 11'b11100100010), rm, 3'b001, 3'd2, 5'd7, 5'd9};
  endfunction

  task automatic run_cmd(input logic [31:0] insn, input logic [VLEN-1:0] b,
                         input logic [VLEN-1:0] s, input logic [PB-1:0] p,
                         input logic [63:0] off, input bit stall, input bit poke,
                         input string tag);
    logic [63:0] qa[$];
    logic [7:0]  qd[$];
    bit legal, wide;
    int es, ne, cyc;
    logic [63:0] eoff, lane;
    legal = (insn[15:13] == 3'b001) &&
            ((insn[31:21] == 11'b11100100010) || (insn[31:21] == 11'b11100100000));
    wide  = (insn[31:21] == 11'b11100100000);
    es    = wide ? 64 : 32;
    ne    = VLEN / es;
    eoff  = (insn[20:16] == 5'd31) ? 64'd0 : off;
    if (legal) begin
      for (int e = 0; e < ne; e++) begin
        if (p[e*(es/8)]) begin
          lane = wide ? b[e*64 +: 64] : {32'b0, b[e*32 +: 32]};
          qa.push_back(lane + eoff);
          qd.push_back(wide ? s[e*64 +: 8] : s[e*32 +: 8]);
        end
      end
    end

    @(negedge clk);
    chk(cmd_ready == 1'b1, {tag, " R12 ready when idle"}, 64'(cmd_ready), 64'd1);
    cmd_insn = insn; cmd_base = b; cmd_src = s; cmd_pred = p; cmd_offset = off;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;

    if (!legal) begin
      chk(undef == 1'b1, {tag, " R3 undef pulse"}, 64'(undef), 64'd1);
      chk(!wr_valid && !done, {tag, " R3 no write/done"}, 64'({wr_valid, done}), 64'd0);
      @(negedge clk);
      chk(!undef && !wr_valid && !done, {tag, " R3 quiet after"}, 64'({undef, wr_valid, done}), 64'd0);
    end else if (qa.size() == 0) begin
      chk(done == 1'b1, {tag, " R11 immediate done"}, 64'(done), 64'd1);
      chk(!wr_valid && !undef, {tag, " R11 no write"}, 64'({wr_valid, undef}), 64'd0);
      @(negedge clk);
      chk(!wr_valid && !done, {tag, " R11 quiet after"}, 64'({wr_valid, done}), 64'd0);
    end else begin
      chk(!wr_valid && !done, {tag, " R12 scan cycle"}, 64'({wr_valid, done}), 64'd0);
      if (poke) begin
        cmd_valid = 1'b1; cmd_base = ~b; cmd_src = ~s; cmd_pred = '1; cmd_insn = mk(1'b1, 5'd1);
      end
      cyc = 0;
      while (qa.size() > 0) begin
        @(negedge clk);
        chk(wr_valid == 1'b1, {tag, " R8 write valid"}, 64'(wr_valid), 64'd1);
        chk(wr_addr == qa[0], {tag, " R4 R5 R8 address"}, wr_addr, qa[0]);
        chk(wr_data == qd[0], {tag, " R6 data byte"}, 64'(wr_data), 64'(qd[0]));
        chk(wr_stream == 1'b1, {tag, " R10 stream hint"}, 64'(wr_stream), 64'd1);
        chk(!done && !cmd_ready, {tag, " R12 busy"}, 64'({done, cmd_ready}), 64'd0);
        wr_ready = stall ? (cyc % 3 == 2) : 1'b1;
        cyc++;
        if (wr_ready) begin
          void'(qa.pop_front());
          void'(qd.pop_front());
        end
      end
      @(negedge clk);
      wr_ready = 1'b0;
      cmd_valid = 1'b0;
      chk(done == 1'b1, {tag, " R12 done after last"}, 64'(done), 64'd1);
      chk(wr_valid == 1'b0, {tag, " R12 R8 no extra write"}, 64'(wr_valid), 64'd0);
      @(negedge clk);
      chk(!done && !wr_valid, {tag, " R12 single done"}, 64'({done, wr_valid}), 64'd0);
    end
  endtask

  initial begin
    #(PERIOD * 150000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [VLEN-1:0] b, s;
    rst = 1'b1; cmd_valid = 1'b0; wr_ready = 1'b0;
    cmd_insn = '0; cmd_base = '0; cmd_src = '0; cmd_pred = '0; cmd_offset = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(cmd_ready && !wr_valid && !done && !undef, "reset state R12",
        64'({cmd_ready, wr_valid, done, undef}), 64'b1000);

    for (int i = 0; i < VLEN/32; i++) begin
      b[i*32 +: 32] = 32'h1000_0000 + 32'(i) * 32'h0001_0111;
      s[i*32 +: 32] = 32'h5A5A_5A00 + 32'(i) * 32'h0101_0113;
    end

    // R1 R4 R6: narrow form, all elements, no stall
    run_cmd(mk(1'b0, 5'd4), b, s, '1, 64'h0000_0001_0000_0000, 1'b0, 1'b0, "narrow all");
    // R2 R7 R9 R8: wide form, sparse, stray non-governing bits, stalls
    run_cmd(mk(1'b1, 5'd2), b, s, 32'h0001_0203, 64'h40, 1'b1, 1'b0, "wide sparse");
    // R5: offset register 31 reads as zero
    run_cmd(mk(1'b0, 5'd31), b, s, 32'h1000_1010, 64'hDEAD_BEEF_0000_0000, 1'b0, 1'b0, "zero reg");
    // R4: 64-bit wrap, wide form
    b[63:0] = 64'hFFFF_FFFF_FFFF_FFF0;
    run_cmd(mk(1'b1, 5'd0), b, s, 32'h0000_0001, 64'h20, 1'b0, 1'b0, "wrap wide");
    // R4: narrow element zero-extended, sum wraps
    b[31:0] = 32'hFFFF_FFFF;
    run_cmd(mk(1'b0, 5'd0), b, s, 32'h0000_0001, 64'hFFFF_FFFF_0000_0010, 1'b1, 1'b0, "wrap narrow");
    // R11: narrow form, no governing bit set
    run_cmd(mk(1'b0, 5'd3), b, s, 32'hEEEE_EEEE, 64'h0, 1'b0, 1'b0, "none narrow");
    // R7 R11: bits active in narrow form are not governing in wide form
    run_cmd(mk(1'b1, 5'd3), b, s, 32'hFEFE_FEFE, 64'h0, 1'b0, 1'b0, "none wide");
    // R3: bad middle field, then bad opcode
    run_cmd({11'b11100100010, 5'd1, 3'b000, 13'd0}, b, s, '1, 64'h0, 1'b0, 1'b0, "undef mid");
    run_cmd({11'b11100100011, 5'd1, 3'b001, 13'd0}, b, s, '1, 64'h0, 1'b0, 1'b0, "undef opc");
    // R12: command offered while busy is ignored
    run_cmd(mk(1'b0, 5'd6), b, s, 32'h0F0F_F0F0, 64'h1234, 1'b1, 1'b1, "busy poke");

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule